// File: doc/BRIEF.md
# Photon Arrival Time-to-Digital Converter Pixel Back End

This block is the digital half of a per-pixel time-to-digital converter. It sits behind a photodiode and a gated ring oscillator. It turns three things into one 10-bit arrival-time code: the oscillator's completed-cycle pulses, a snapshot of its eight phase taps, and a photon-driven start/reset line. The measurement runs in reverse order. A photon event on the start/reset line arms the pixel. A chip-wide stop edge then freezes it and ends the window. The code has a coarse part and a fine part. The upper seven bits count ring cycles, at 440 ps each. The lower three bits decode the latched thermometer snapshot of the taps, at 55 ps each. The full scale is about 55 ns.

A mode input changes the pixel into a photon counter. In this mode the same 10-bit register counts photon events between stops. The finished result is written into a pixel memory register, which readout can scan while the next window is already running. In timing mode only one stop out of every KEEP_RATIO updates this memory (the default is one in ten). This matches a 100 ns measurement rate against a 1 µs minimum frame.

Top module: `tdc_pixel_backend`

## Requirements
- R1: After reset, `code` is 0 and `code_ovf` is 0.
- R2: In timing mode (`count_mode`=0), a kept result has `code[9:3]` equal to the number of cycles in which `ring_carry` was high while the pixel was armed and `stop` was low. `code[2:0]` is the decoded fine value.
- R3: In timing mode, a falling edge of `start_n` while `stop` is low arms the pixel. A rising edge of `start_n` disarms it and clears the cycle count and the tap latch, so only carries after a later falling edge are counted.
- R4: `phase_taps` are captured on a cycle with `xfer` high only while the pixel is armed in timing mode. The fine value is the length of the unbroken run of ones starting at `phase_taps[0]`. Every bit after the first zero is treated as zero, and a run of eight gives 7.
- R5: A rising edge of `stop` ends the window, and all counting state is clear after it. While `stop` is high, `ring_carry`, `xfer` and `start_n` falling edges have no effect.
- R6: When a carry or event arrives with the count already at its maximum, the count saturates instead of wrapping and the overflow flag is set. The maximum is 127 cycles in timing mode and 1023 in counting mode. In timing mode a saturated code is `{7'h7F, fine}` with `code_ovf`=1.
- R7: A kept timing-mode stop with no arming in its window writes the no-photon code 10'h3FF with `code_ovf`=0.
- R8: In timing mode, a stop updates memory only if it is the first of a group of KEEP_RATIO (10) timing-mode stops counted from reset. On the other stops `code` and `code_ovf` hold their values.
- R9: In counting mode (`count_mode`=1), every falling edge of `start_n` with `stop` low adds one, and rising edges do not clear. Every stop writes the count and its overflow flag to memory.
- R10: Memory updates on the clock edge that first samples `stop` high, and `code` shows the new value from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_taps | input | 8 | Ring oscillator phase taps, thermometer pattern |
| ring_carry | input | 1 | High for one cycle per completed ring cycle |
| start_n | input | 1 | Photon start (falling) / clear (rising) line |
| stop | input | 1 | Global stop, rising edge ends the window |
| xfer | input | 1 | Tap snapshot strobe |
| count_mode | input | 1 | 0 = arrival timing, 1 = photon counting |
| code | output | 10 | Pixel memory: arrival code or event count |
| code_ovf | output | 1 | Overflow flag stored with the code |

## Verification
Every result of this block appears at `code` on the clock edge that samples `stop` rising. The bench drives inputs on falling clock edges. It raises `stop` on one falling edge and compares `code` and `code_ovf` on the next falling edge, after exactly one register stage. Arming, carries and tap captures take effect on the edge that samples them. The bench therefore places each carry and each strobe on its own cycle, after the arming edge and before the stop. This way every stimulus lands inside the window that the expected value assumes. The bench keeps its own count of timing-mode stops, so it knows which windows must reach memory and which must leave it unchanged.

// File: rtl/tdc_pixel_pkg.sv
package tdc_pixel_pkg;
  localparam int FINE_W   = 3;
  localparam int COARSE_W = 7;
  localparam int TAPS     = 1 << FINE_W;
  localparam int CODE_W   = COARSE_W + FINE_W;

  typedef enum logic {
    MODE_TIMING = 1'b0,
    MODE_COUNT  = 1'b1
  } tdc_mode_e;
endpackage

// File: rtl/tdc_fine_capture.sv
module tdc_fine_capture #(
  parameter int TAPS   = 8,
  parameter int FINE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [TAPS-1:0]   taps,
  output logic [FINE_W-1:0] fine
);
  localparam int RUN_W = $clog2(TAPS + 1);
  localparam logic [RUN_W-1:0] FINE_MAX = RUN_W'((1 << FINE_W) - 1);

  logic [TAPS-1:0]  latch_q, latch_d;
  logic [RUN_W-1:0] run_len;
  logic             run_on;

  // next-state
  always_comb begin
    latch_d = latch_q;
    if (clr)       latch_d = '0;
    else if (load) latch_d = taps;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  // leading run of ones from tap 0; anything past the first zero is dropped
  always_comb begin
    run_on  = 1'b1;
    run_len = '0;
    for (int i = 0; i < TAPS; i++) begin
      run_on = run_on & latch_q[i];
      if (run_on) run_len = run_len + RUN_W'(1);
    end
    if (run_len > FINE_MAX) fine = FINE_MAX[FINE_W-1:0];
    else                    fine = run_len[FINE_W-1:0];
  end

  AST_LATCH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fine == '0)) else $error("latch not cleared"); // R3
endmodule

// File: rtl/tdc_event_counter.sv
module tdc_event_counter #(
  parameter int CODE_W = 10,
  parameter int FINE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic              count_mode,
  output logic [CODE_W-1:0] cnt_q,
  output logic              ovf_q
);
  localparam logic [CODE_W-1:0] LOW_MASK    = CODE_W'((1 << FINE_W) - 1);
  localparam logic [CODE_W-1:0] COARSE_STEP = CODE_W'(1 << FINE_W);

  logic [CODE_W-1:0] cnt_d, step, mask;
  logic              ovf_d, at_max;

  // timing mode advances the upper field only; counting mode uses every bit
  always_comb begin
    mask   = count_mode ? '0 : LOW_MASK;
    step   = count_mode ? CODE_W'(1) : COARSE_STEP;
    at_max = &(cnt_q | mask);
  end

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (inc) begin
      if (at_max) ovf_d = 1'b1;
      else        cnt_d = cnt_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  AST_NO_OVERFLOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> (ovf_q && $stable(cnt_q))) else $error("count wrapped"); // R6
  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !ovf_q)) else $error("count not cleared"); // R5
endmodule

// File: rtl/tdc_pixel_mem.sv
module tdc_pixel_mem #(
  parameter int CODE_W     = 10,
  parameter int FINE_W     = 3,
  parameter int KEEP_RATIO = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_evt,
  input  logic              count_mode,
  input  logic              armed,
  input  logic [CODE_W-1:0] cnt,
  input  logic              cnt_ovf,
  input  logic [FINE_W-1:0] fine,
  output logic [CODE_W-1:0] code_q,
  output logic              ovf_q
);
  localparam int KEEP_W = (KEEP_RATIO > 1) ? $clog2(KEEP_RATIO) : 1;
  localparam logic [KEEP_W-1:0] KEEP_LAST = KEEP_W'(KEEP_RATIO - 1);

  logic [KEEP_W-1:0] keep_q, keep_d;
  logic [CODE_W-1:0] code_d, time_code;
  logic              ovf_d, keep_slot;

  always_comb begin
    time_code = {cnt[CODE_W-1:FINE_W], fine};
    keep_slot = (keep_q == '0);
    keep_d    = keep_q;
    code_d    = code_q;
    ovf_d     = ovf_q;
    if (stop_evt) begin
      if (count_mode) begin
        code_d = cnt;
        ovf_d  = cnt_ovf;
      end else begin
        keep_d = (keep_q == KEEP_LAST) ? '0 : keep_q + KEEP_W'(1);
        if (keep_slot) begin
          code_d = armed ? time_code : '1;
          ovf_d  = armed & cnt_ovf;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q <= '0;
      code_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      keep_q <= keep_d;
      code_q <= code_d;
      ovf_q  <= ovf_d;
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_evt |=> ($stable(code_q) && $stable(ovf_q))) else $error("memory moved"); // R8
  AST_SKIPPED_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !count_mode && !keep_slot) |=> $stable(code_q)) else $error("skipped stop wrote"); // R8
  AST_NO_PHOTON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !count_mode && keep_slot && !armed) |=> (code_q == '1 && !ovf_q)) else $error("no-photon code"); // R7
  AST_KEEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    keep_q <= KEEP_LAST) else $error("keep index range"); // R8
endmodule

// File: rtl/tdc_pixel_backend.sv
module tdc_pixel_backend
  import tdc_pixel_pkg::*;
#(
  parameter int KEEP_RATIO = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAPS-1:0]   phase_taps,
  input  logic              ring_carry,
  input  logic              start_n,
  input  logic              stop,
  input  logic              xfer,
  input  logic              count_mode,
  output logic [CODE_W-1:0] code,
  output logic              code_ovf
);
  tdc_mode_e         mode;
  logic              start_q, stop_q, armed_q, armed_d;
  logic              start_fall, start_rise, stop_rise;
  logic              cnt_clr, cnt_inc, tap_load;
  logic [CODE_W-1:0] cnt;
  logic              cnt_ovf;
  logic [FINE_W-1:0] fine;

  always_comb begin
    mode       = tdc_mode_e'(count_mode);
    start_fall = start_q & ~start_n;
    start_rise = ~start_q & start_n;
    stop_rise  = stop & ~stop_q;
  end

  // window control
  always_comb begin
    armed_d  = armed_q;
    cnt_clr  = stop_rise | ((mode == MODE_TIMING) & start_rise);
    cnt_inc  = 1'b0;
    tap_load = 1'b0;
    if (cnt_clr) begin
      armed_d = 1'b0;
    end else if (!stop) begin
      if (mode == MODE_TIMING) begin
        if (start_fall) armed_d = 1'b1;
        cnt_inc  = armed_q & ring_carry;
        tap_load = armed_q & xfer;
      end else begin
        cnt_inc = start_fall;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b1;
      stop_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      start_q <= start_n;
      stop_q  <= stop;
      armed_q <= armed_d;
    end
  end

  tdc_event_counter #(.CODE_W(CODE_W), .FINE_W(FINE_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .count_mode(count_mode), .cnt_q(cnt), .ovf_q(cnt_ovf)
  );

  tdc_fine_capture #(.TAPS(TAPS), .FINE_W(FINE_W)) u_fine (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .load(tap_load),
    .taps(phase_taps), .fine(fine)
  );

  tdc_pixel_mem #(.CODE_W(CODE_W), .FINE_W(FINE_W), .KEEP_RATIO(KEEP_RATIO)) u_mem (
    .clk(clk), .rst_n(rst_n), .stop_evt(stop_rise), .count_mode(count_mode),
    .armed(armed_q), .cnt(cnt), .cnt_ovf(cnt_ovf), .fine(fine),
    .code_q(code), .ovf_q(code_ovf)
  );

  AST_ARM_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(start_fall)) else $error("armed without photon"); // R3
  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rise |=> !armed_q) else $error("still armed after stop"); // R5
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && stop_q) |=> $stable(cnt)) else $error("count moved while stopped"); // R5
endmodule

// File: tb/tdc_pixel_backend_tb_top.sv
module tdc_pixel_backend_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int KEEP       = 10;

  logic       clk;
  logic       rst_n;
  logic [7:0] phase_taps;
  logic       ring_carry, start_n, stop, xfer, count_mode;
  logic [9:0] code;
  logic       code_ovf;

  int n_vec;
  int n_bad;
  int keep_idx;
  logic [9:0] exp_code;
  logic       exp_ovf;

  tdc_pixel_backend #(.KEEP_RATIO(KEEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .phase_taps(phase_taps), .ring_carry(ring_carry),
    .start_n(start_n), .stop(stop), .xfer(xfer), .count_mode(count_mode),
    .code(code), .code_ovf(code_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] fine_of(logic [7:0] t);
    int  r;
    bit  on;
    r  = 0;
    on = 1'b1;
    for (int i = 0; i < 8; i++) begin
      on = on & t[i];
      if (on) r++;
    end
    if (r > 7) r = 7;
    return 3'(r);
  endfunction

  task automatic check(string req);
    n_vec++;
    if (code !== exp_code || code_ovf !== exp_ovf) begin
      n_bad++;
      $display("FAIL %s: code=%h ovf=%b expected code=%h ovf=%b", req, code, code_ovf, exp_code, exp_ovf);
    end
  endtask

  task automatic end_window();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0; start_n = 1'b1;
  endtask

  // one timing window; R2 R3 R4 R6 R7 R8
  task automatic timing_window(bit photon, int ncar, logic [7:0] taps, bit mid_clear, int ncar2, string req);
    int n;
    @(negedge clk); count_mode = 1'b0; stop = 1'b0; start_n = 1'b1;
    if (photon) begin
      @(negedge clk); start_n = 1'b0;
    end
    for (int i = 0; i < ncar; i++) begin
      @(negedge clk); ring_carry = 1'b1;
      @(negedge clk); ring_carry = 1'b0;
    end
    n = ncar;
    if (photon && mid_clear) begin
      @(negedge clk); start_n = 1'b1;
      @(negedge clk); start_n = 1'b0;
      for (int i = 0; i < ncar2; i++) begin
        @(negedge clk); ring_carry = 1'b1;
        @(negedge clk); ring_carry = 1'b0;
      end
      n = ncar2;
    end
    @(negedge clk); phase_taps = taps; xfer = 1'b1;
    @(negedge clk); xfer = 1'b0; phase_taps = $urandom;
    end_window();
    if (keep_idx == 0) begin
      if (photon) begin
        exp_code = {((n > 127) ? 7'h7F : 7'(n)), fine_of(taps)};
        exp_ovf  = (n > 127);
      end else begin
        exp_code = 10'h3FF;
        exp_ovf  = 1'b0;
      end
    end
    keep_idx = (keep_idx + 1) % KEEP;
    check(req);
  endtask

  task automatic count_window(int nev, string req);
    @(negedge clk); count_mode = 1'b1; stop = 1'b0; start_n = 1'b1;
    for (int i = 0; i < nev; i++) begin
      @(negedge clk); start_n = 1'b0; ring_carry = $urandom;
      @(negedge clk); start_n = 1'b1; ring_carry = 1'b0;
    end
    end_window();
    exp_code = (nev > 1023) ? 10'h3FF : 10'(nev);
    exp_ovf  = (nev > 1023);
    check(req);
  endtask

  task automatic align_keep();
    while (keep_idx != 0) timing_window(1'b0, 0, 8'h00, 1'b0, 0, "R7 align");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_7DC1));
    n_vec = 0; n_bad = 0; keep_idx = 0;
    rst_n = 1'b0; phase_taps = '0; ring_carry = 1'b0; start_n = 1'b1;
    stop = 1'b0; xfer = 1'b0; count_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_code = '0; exp_ovf = 1'b0;
    check("R1 reset");

    // R2 R4 R10: kept window, full thermometer
    timing_window(1'b1, 5, 8'h1F, 1'b0, 0, "R2 R4 R10 basic arrival");
    // R8: next nine stops do not write
    timing_window(1'b1, 20, 8'h03, 1'b0, 0, "R8 skipped stop holds");
    align_keep();
    // R4: bubble after first zero ignored
    timing_window(1'b1, 9, 8'b1011_0111, 1'b0, 0, "R4 bubble suppressed");
    align_keep();
    // R4: all eight taps high gives 7
    timing_window(1'b1, 0, 8'hFF, 1'b0, 0, "R4 full run saturates");
    align_keep();
    // R7: no photon
    timing_window(1'b0, 12, 8'hFF, 1'b0, 0, "R7 no photon code");
    align_keep();
    // R6: coarse saturation
    timing_window(1'b1, 135, 8'h07, 1'b0, 0, "R6 coarse overflow");
    align_keep();
    // R6: exactly 127 carries, no flag
    timing_window(1'b1, 127, 8'h00, 1'b0, 0, "R6 maximum without overflow");
    align_keep();
    // R3: rising start_n clears mid window
    timing_window(1'b1, 40, 8'h01, 1'b1, 6, "R3 mid-window clear");
    align_keep();

    // R9: counting mode
    count_window(17, "R9 count events");
    count_window(0, "R9 zero events");
    count_window(1030, "R9 R6 count saturation");

    // R5: start_n falls and carries while stop high are ignored
    @(negedge clk); count_mode = 1'b1; stop = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); start_n = 1'b0; ring_carry = 1'b1;
      @(negedge clk); start_n = 1'b1; ring_carry = 1'b0;
    end
    @(negedge clk); stop = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); start_n = 1'b0;
      @(negedge clk); start_n = 1'b1;
    end
    end_window();
    exp_code = 10'd2; exp_ovf = 1'b0;
    check("R5 events ignored under stop");

    // random mix
    for (int w = 0; w < 70; w++) begin
      if (($urandom % 5) == 0) count_window($urandom % 40, "R9 random count");
      else timing_window(($urandom % 4) != 0, $urandom % 145, 8'($urandom),
                         ($urandom % 3) == 0, $urandom % 30, "R2 R8 random timing");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule